// File: doc/BRIEF.md
# Nibble-Serial Byte ALU

This block performs byte-wide arithmetic and logic on two operands using a datapath only one nibble wide. A start strobe captures both operands and the operation controls into holding registers. The shared nibble core then makes two passes. The first pass works on the lower halves and parks its result and its carry. The second pass works on the upper halves, using the parked carry as its carry input. The finished byte appears together with a one-cycle done pulse.

The core does not pick its function from a result multiplexer. Three control lines gate the carry logic inside each bit cell, and this gating turns the same cell into an adder, an XOR, an AND or an OR. The second operand can be bitwise inverted on its way into the core. With the external carry input set to 1, this gives subtraction, negation and comparison. Flags for zero, parity and per-nibble "below ten" are derived from the byte being output. The block has no register file access and no instruction decode.

Top module: `nibble_alu`

## Requirements
- R1: On a cycle with start_i high and no operation in progress, the block captures opa_i, opb_i, kill_chain_i, kill_gen_i, or_path_i, invert_b_i and carry_i. Changes on these inputs after that cycle do not affect the result of that operation.
- R2: done_o is high for exactly one cycle, the second cycle after the accepted start cycle. It is low in the cycle directly after the start.
- R3: start_i is ignored in the two cycles that follow an accepted start. Such a strobe causes no extra done pulse and does not change the result.
- R4: With controls (kill_chain, kill_gen, or_path) = (0,0,0), the result is opa + opb' + carry_i modulo 256. Here opb' is opb or its inverse, and the low-nibble carry feeds the high nibble. carry_o is the carry out of bit 7.
- R5: With invert_b_i = 1 the core uses the bitwise inverse of opb. With carry_i = 1 and sum controls, this yields opa - opb, where carry_o = 1 means no borrow. With opa = 0 it yields the negation of opb.
- R6: Controls (1,0,0) give opa XOR opb'. carry_i is ignored and carry_o is 0.
- R7: Controls (0,1,0) give opa AND opb'. carry_i is ignored and carry_o is 0.
- R8: Controls (1,1,1) give opa OR opb'. carry_i is ignored and carry_o is 0.
- R9: result_o and carry_o keep the value shown in the done cycle until the next done cycle.
- R10: zero_o is 1 exactly when all 8 bits of result_o are 0.
- R11: parity_o is 1 exactly when result_o holds an even number of 1 bits.
- R12: lo_lt10_o is 1 when result_o[3:0] is below 10. hi_lt10_o is 1 when result_o[7:4] is below 10.
- R13: After reset, result_o is 0, carry_o is 0 and done_o is 0. The flags match this zero result: zero_o = 1, parity_o = 1, lo_lt10_o = 1, hi_lt10_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an operation |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| kill_chain_i | input | 1 | Blocks the carry passed between bit cells |
| kill_gen_i | input | 1 | Forces each cell's internal carry to 0 |
| or_path_i | input | 1 | Enables the OR path of the result logic |
| invert_b_i | input | 1 | Use the bitwise inverse of the second operand |
| carry_i | input | 1 | Carry into bit 0 of the low pass |
| result_o | output | 8 | Byte result |
| carry_o | output | 1 | Carry out of bit 7 |
| done_o | output | 1 | Result valid pulse |
| zero_o | output | 1 | Result is zero |
| parity_o | output | 1 | Result has even parity |
| lo_lt10_o | output | 1 | Low result nibble is below ten |
| hi_lt10_o | output | 1 | High result nibble is below ten |

## Verification
The bench builds the block with its default parameters: a 4-bit nibble, an 8-bit byte and a below-ten limit of 10. With these values, every carry that crosses from the low pass to the high pass can be seen at the ports, as in 0x0F + 0x01 and in a wrap to zero with carry out. The nibble flags also have reachable values on both sides of the limit. The vectors cover each of the four control encodings, with and without the inverted operand. Directed sequences change inputs and pulse start while an operation runs, then check that the held result and the done timing are unaffected.

// File: rtl/nalu_pkg.sv
// Shared types for the nibble-serial ALU.
// Assumes: the three core control lines are always handled as one group.
package nalu_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2
    } phase_e;

    typedef struct packed {
        logic kill_chain;   // blocks carry passed to the next cell
        logic kill_gen;     // forces the internal carry to zero
        logic or_path;      // opens the OR term of the result logic
    } core_ctl_t;

endpackage

// File: rtl/nalu_cell.sv
// One bit cell of the nibble core. The carry gating picks the function:
//   (chain,gen,or) 000 sum, 100 xor, 010 and, 111 or.
// Assumes: other control codes are never issued.
module nalu_cell
    import nalu_pkg::*;
(
    input  logic      a_i,
    input  logic      b_i,
    input  logic      cin_i,
    input  core_ctl_t ctl_i,
    output logic      res_o,
    output logic      cout_o
);

    logic cin_eff;
    logic int_carry;
    logic and_term;
    logic any_term;

    // Derive the gated carries and the result bit from the operand bits.
    always_comb begin
        cin_eff   = cin_i & ~ctl_i.kill_chain;
        int_carry = ~ctl_i.kill_gen & ((a_i & b_i) | (cin_eff & (a_i | b_i)));
        and_term  = a_i & b_i & (cin_eff | ctl_i.kill_gen);
        any_term  = (a_i | b_i | cin_eff) & ~int_carry
                    & ~(ctl_i.kill_gen & ~ctl_i.or_path);
        res_o     = and_term | any_term;
        cout_o    = int_carry & ~ctl_i.kill_chain;
    end

endmodule

// File: rtl/nalu_core.sv
// Nibble-wide core: a ripple chain of bit cells that share one control group.
// Assumes: NIB_W >= 1; the carry out is taken from the top cell.
module nalu_core
    import nalu_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic [NIB_W-1:0] a_i,
    input  logic [NIB_W-1:0] b_i,
    input  logic             cin_i,
    input  core_ctl_t        ctl_i,
    output logic [NIB_W-1:0] res_o,
    output logic             cout_o
);

    logic [NIB_W:0] chain;

    assign chain[0] = cin_i;

    for (genvar i = 0; i < NIB_W; i++) begin : g_bit
        nalu_cell u_cell (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .cin_i  (chain[i]),
            .ctl_i  (ctl_i),
            .res_o  (res_o[i]),
            .cout_o (chain[i+1])
        );
    end

    assign cout_o = chain[NIB_W];

endmodule

// File: rtl/nalu_flags.sv
// Status flags over the byte being output: zero, even parity and a
// per-nibble "below limit" indication.
// Assumes: the input byte is two nibbles of NIB_W bits.
module nalu_flags #(
    parameter int NIB_W    = 4,
    parameter int LT_LIMIT = 10,
    localparam int DATA_W  = 2 * NIB_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic              zero_o,
    output logic              parity_o,
    output logic              lo_lt_o,
    output logic              hi_lt_o
);

    localparam logic [NIB_W:0] LIMIT = (NIB_W+1)'(LT_LIMIT);

    // Reduce the byte into the four flag bits.
    always_comb begin
        zero_o   = (data_i == '0);
        parity_o = ~(^data_i);
        lo_lt_o  = {1'b0, data_i[NIB_W-1:0]} < LIMIT;
        hi_lt_o  = {1'b0, data_i[DATA_W-1:NIB_W]} < LIMIT;
    end

endmodule

// File: rtl/nalu_seq.sv
// Pass sequencer: idle -> low pass -> high pass -> idle. Start is honoured
// only in idle. The high-pass cycle is the cycle the byte result is valid.
// Assumes: synchronous active-low reset.
module nalu_seq
    import nalu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    output phase_e phase_o,
    output logic   capture_o,
    output logic   lo_pass_o,
    output logic   hi_pass_o
);

    phase_e phase_q;
    phase_e phase_d;

    // Decode the pass strobes and the next phase.
    always_comb begin
        capture_o = start_i && (phase_q == PH_IDLE);
        lo_pass_o = (phase_q == PH_LO);
        hi_pass_o = (phase_q == PH_HI);
        unique case (phase_q)
            PH_IDLE: phase_d = capture_o ? PH_LO : PH_IDLE;
            PH_LO:   phase_d = PH_HI;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/nibble_alu.sv
// Byte ALU over a shared nibble core, run in two sequenced passes.
// Operands and controls are latched at start. The low pass stores its nibble
// and carry; the high pass completes the byte, which is shown live in that
// cycle with done_o and then held.
// Assumes: start_i is a synchronous strobe; outputs are registered or held.
module nibble_alu
    import nalu_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int LT_LIMIT = 10,
    localparam int DATA_W  = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              kill_chain_i,
    input  logic              kill_gen_i,
    input  logic              or_path_i,
    input  logic              invert_b_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              done_o,
    output logic              zero_o,
    output logic              parity_o,
    output logic              lo_lt10_o,
    output logic              hi_lt10_o
);

    phase_e            phase_q;
    logic              capture;
    logic              lo_pass;
    logic              hi_pass;

    logic [DATA_W-1:0] opa_q;
    logic [DATA_W-1:0] opb_q;
    core_ctl_t         ctl_q;
    logic              inv_q;
    logic              cin_q;

    logic [NIB_W-1:0]  lo_res_q;
    logic              mid_carry_q;
    logic [DATA_W-1:0] hold_res_q;
    logic              hold_carry_q;

    logic [NIB_W-1:0]  a_nib;
    logic [NIB_W-1:0]  b_sel;
    logic [NIB_W-1:0]  b_nib;
    logic              core_cin;
    logic [NIB_W-1:0]  core_res;
    logic              core_cout;
    logic [DATA_W-1:0] byte_out;

    nalu_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .phase_o   (phase_q),
        .capture_o (capture),
        .lo_pass_o (lo_pass),
        .hi_pass_o (hi_pass)
    );

    // Latch both operands and the operation controls on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
            ctl_q <= '0;
            inv_q <= 1'b0;
            cin_q <= 1'b0;
        end else if (capture) begin
            opa_q <= opa_i;
            opb_q <= opb_i;
            ctl_q <= '{kill_chain: kill_chain_i, kill_gen: kill_gen_i,
                       or_path: or_path_i};
            inv_q <= invert_b_i;
            cin_q <= carry_i;
        end
    end

    // Pick the nibble for this pass and apply the optional inversion.
    always_comb begin
        a_nib    = hi_pass ? opa_q[DATA_W-1:NIB_W] : opa_q[NIB_W-1:0];
        b_sel    = hi_pass ? opb_q[DATA_W-1:NIB_W] : opb_q[NIB_W-1:0];
        b_nib    = inv_q ? ~b_sel : b_sel;
        core_cin = hi_pass ? mid_carry_q : cin_q;
    end

    nalu_core #(.NIB_W(NIB_W)) u_core (
        .a_i    (a_nib),
        .b_i    (b_nib),
        .cin_i  (core_cin),
        .ctl_i  (ctl_q),
        .res_o  (core_res),
        .cout_o (core_cout)
    );

    // Park the low-pass nibble and its carry for the high pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_res_q    <= '0;
            mid_carry_q <= 1'b0;
        end else if (lo_pass) begin
            lo_res_q    <= core_res;
            mid_carry_q <= core_cout;
        end
    end

    // Keep the finished byte and carry until the next high pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_res_q   <= '0;
            hold_carry_q <= 1'b0;
        end else if (hi_pass) begin
            hold_res_q   <= {core_res, lo_res_q};
            hold_carry_q <= core_cout;
        end
    end

    // Show the live byte in the high-pass cycle, the held byte otherwise.
    always_comb begin
        byte_out = hi_pass ? {core_res, lo_res_q} : hold_res_q;
        carry_o  = hi_pass ? core_cout : hold_carry_q;
        done_o   = hi_pass;
    end

    assign result_o = byte_out;

    nalu_flags #(.NIB_W(NIB_W), .LT_LIMIT(LT_LIMIT)) u_flags (
        .data_i   (byte_out),
        .zero_o   (zero_o),
        .parity_o (parity_o),
        .lo_lt_o  (lo_lt10_o),
        .hi_lt_o  (hi_lt10_o)
    );

endmodule

// File: rtl/nalu_chk.sv
// Protocol and flag checker for nibble_alu, attached by bind.
// Assumes: it sees the sequencer phase and latched controls of the top.
module nalu_chk
    import nalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              done_o,
    input logic              carry_o,
    input logic [DATA_W-1:0] result_o,
    input logic              zero_o,
    input logic              parity_o,
    input phase_e            phase_q,
    input core_ctl_t         ctl_q
);

    // R2: an accepted start gives done two cycles later, not one.
    a_r2_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && phase_q == PH_IDLE) |=> (!done_o ##1 done_o));

    // R2: done never lasts two cycles.
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: a low pass always proceeds to the high pass, whatever start does.
    a_r3_lo_to_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LO) |=> (phase_q == PH_HI));

    // R3: the high pass always returns to idle, whatever start does.
    a_r3_hi_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HI) |=> (phase_q == PH_IDLE));

    // R9: outside a done cycle the result and carry do not move.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(carry_o)));

    // R6, R7, R8: logic operations never report a carry.
    a_r6_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (ctl_q.kill_chain || ctl_q.kill_gen)) |-> !carry_o);

    // R10: zero flag tracks the output byte.
    a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == ($countones(result_o) == 0));

    // R11: parity flag reports an even count of ones.
    a_r11_parity: assert property (@(posedge clk) disable iff (!rst_n)
        parity_o == ($countones(result_o) % 2 == 0));

endmodule

bind nibble_alu nalu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .done_o   (done_o),
    .carry_o  (carry_o),
    .result_o (result_o),
    .zero_o   (zero_o),
    .parity_o (parity_o),
    .phase_q  (phase_q),
    .ctl_q    (ctl_q)
);

// File: tb/sim_nibble_alu.sv
module sim_nibble_alu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] opa_i = '0;
    logic [7:0] opb_i = '0;
    logic       kill_chain_i = 1'b0;
    logic       kill_gen_i = 1'b0;
    logic       or_path_i = 1'b0;
    logic       invert_b_i = 1'b0;
    logic       carry_i = 1'b0;
    logic [7:0] result_o;
    logic       carry_o;
    logic       done_o;
    logic       zero_o;
    logic       parity_o;
    logic       lo_lt10_o;
    logic       hi_lt10_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    nibble_alu u0 (.*);

    // Vector: a, b, {chain,gen,or,inv,cin}, expected result, expected carry.
    localparam int NV = 12;
    localparam logic [29:0] VEC [NV] = '{
        {8'h3A, 8'h45, 5'b00000, 8'h7F, 1'b0},  // R4 add
        {8'h0F, 8'h01, 5'b00000, 8'h10, 1'b0},  // R4 nibble carry
        {8'hFF, 8'h01, 5'b00000, 8'h00, 1'b1},  // R4 wrap with carry
        {8'h12, 8'h34, 5'b00001, 8'h47, 1'b0},  // R4 carry_i
        {8'h50, 8'h21, 5'b00011, 8'h2F, 1'b1},  // R5 subtract
        {8'h10, 8'h20, 5'b00011, 8'hF0, 1'b0},  // R5 borrow
        {8'h42, 8'h42, 5'b00011, 8'h00, 1'b1},  // R5 compare equal
        {8'h00, 8'h01, 5'b00011, 8'hFF, 1'b0},  // R5 negate
        {8'hF0, 8'h3C, 5'b10001, 8'hCC, 1'b0},  // R6 xor
        {8'h0F, 8'h0F, 5'b10011, 8'hFF, 1'b0},  // R6 xor inverted
        {8'hF0, 8'h3C, 5'b01001, 8'h30, 1'b0},  // R7 and
        {8'hA0, 8'h05, 5'b11101, 8'hA5, 1'b0}   // R8 or
    };
    localparam string TAG [NV] = '{"R4", "R4", "R4", "R4", "R5", "R5",
                                   "R5", "R5", "R6", "R6", "R7", "R8"};

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input logic [7:0] r);
        chk("R10", {31'd0, zero_o}, {31'd0, r == 8'h00});
        chk("R11", {31'd0, parity_o}, {31'd0, ~(^r)});
        chk("R12", {30'd0, hi_lt10_o, lo_lt10_o},
            {30'd0, r[7:4] < 4'd10, r[3:0] < 4'd10});
    endtask

    // Drive one operation at a negedge; returns at the done-cycle negedge.
    task automatic launch(input logic [7:0] a, input logic [7:0] b,
                          input logic [4:0] c);
        @(negedge clk);
        opa_i = a; opb_i = b;
        {kill_chain_i, kill_gen_i, or_path_i, invert_b_i, carry_i} = c;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2", {31'd0, done_o}, 32'd0);
        @(negedge clk);
        chk("R2", {31'd0, done_o}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: reset state
        chk("R13", {23'd0, done_o, carry_o, result_o}, 32'd0);
        chk("R13", {28'd0, zero_o, parity_o, lo_lt10_o, hi_lt10_o}, 32'hF);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            launch(VEC[i][29:22], VEC[i][21:14], VEC[i][13:9]);
            chk(TAG[i], {23'd0, carry_o, result_o}, {23'd0, VEC[i][0], VEC[i][8:1]});
            chk_flags(result_o);
        end

        // R1: inputs changed after the start cycle have no effect.
        @(negedge clk);
        opa_i = 8'h11; opb_i = 8'h22;
        {kill_chain_i, kill_gen_i, or_path_i, invert_b_i, carry_i} = 5'b00000;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        opa_i = 8'hFF; opb_i = 8'hFF;
        {kill_chain_i, kill_gen_i, or_path_i, invert_b_i, carry_i} = 5'b11111;
        @(negedge clk);
        chk("R1", {23'd0, done_o, result_o}, {23'd1, 8'h33});

        // R3: start pulses during both passes are ignored.
        @(negedge clk);
        opa_i = 8'h05; opb_i = 8'h03;
        {kill_chain_i, kill_gen_i, or_path_i, invert_b_i, carry_i} = 5'b00000;
        start_i = 1'b1;
        @(negedge clk);
        opa_i = 8'h70; opb_i = 8'h70;          // start still high in low pass
        @(negedge clk);                        // start still high in high pass
        chk("R3", {23'd0, done_o, result_o}, {23'd1, 8'h08});
        start_i = 1'b0;
        @(negedge clk);
        chk("R3", {31'd0, done_o}, 32'd0);
        // R9: value held after the done cycle
        chk("R9", {23'd0, carry_o, result_o}, {23'd0, 8'h08});
        repeat (4) @(negedge clk);
        chk("R9", {22'd0, done_o, carry_o, result_o}, {22'd0, 8'h08});
        chk_flags(8'h08);

        // R9: a carry result is also held after done.
        launch(8'hFF, 8'h01, 5'b00000);
        repeat (3) @(negedge clk);
        chk("R9", {23'd0, carry_o, result_o}, {23'd1, 8'h00});

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule